// File: doc/BRIEF.md
# External Pin Edge Capture and Counter-Reset Unit

This block sits beside a 24-bit timer counter and watches one external pin. The pin is brought into the clock domain by a two-flop synchronizer. It can then pass through an optional debounce filter, and a configurable edge detector follows. Edge detection can select falling, rising or both edges, or be switched off with the spare code. Each qualifying edge is sent one of two ways, chosen by a single mode bit. In capture mode the live timer count is copied into a read-only capture register and an event flag is raised. In reset mode a one-cycle pulse is sent to the timer counter so that it restarts.

Software uses a small register port. It has a write strobe with address and data, plus a combinational read mux. The control register holds the pin enable, the edge code, the capture/reset mode, the interrupt enable and the debounce enable. The event flag is cleared by writing 1 to it, and the interrupt line is the flag gated by its enable. The counter itself lies outside the block. Only its count value comes in, and only the reset pulse goes out.

Top module: `extpin_capture`

## Requirements
- R1: Control bits [2:1] select the edge: 00 detects a 1-to-0 transition, 01 detects a 0-to-1 transition, and 10 detects either transition. Only the selected kind of edge produces an event.
- R2: Edge code 11 produces no event at all. The capture value, the flag and the reset pulse do not change.
- R3: When control bit 0 (pin enable) is 0, pin transitions cause no capture, no flag and no reset pulse.
- R4: When control bit 3 (mode) is 0, a qualifying edge loads the current count_in into the capture register and sets the event flag.
- R5: When control bit 3 is 1, a qualifying edge produces a reset pulse that is high for exactly one cycle per edge. The flag is not set and the capture value is kept.
- R6: The event flag is cleared only by a write of data bit 0 = 1 to address 1. Writing 0 there leaves it unchanged.
- R7: ext_irq is high exactly when the flag is 1 and control bit 4 (interrupt enable) is 1.
- R8: When control bit 5 (debounce enable) is 1, a new synchronized pin level is accepted only after three consecutive identical samples. A two-cycle glitch is then rejected. With bit 5 at 0, the same glitch is detected.
- R9: The capture register is read at address 2 and cannot be written: a write to address 2 has no effect.
- R10: If a flag-clear write and a new capture event fall in the same cycle, the flag ends up set.
- R11: After reset the control register, the capture value, the flag, the interrupt and the reset pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous external pin |
| count_in | input | 24 | Live timer count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 flag, 2 capture (ignored) |
| wr_data | input | 6 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 24 | Read data, combinational |
| cap_value | output | 24 | Captured count |
| cnt_rst | output | 1 | One-cycle counter-reset pulse |
| ext_flag | output | 1 | External event flag |
| ext_irq | output | 1 | Gated interrupt |

## Verification
A bad synchronizer or edge-history register shows up as a missed edge, a doubled edge or an edge of the wrong kind. This is seen at cap_value, ext_flag or cnt_rst two cycles after the pin change, or five cycles after it when the debounce filter is on. A wrong debounce history either lets a two-cycle glitch reach the capture register or delays a held level past its five-cycle point. A wrong flag or mode bit shows on ext_flag and ext_irq in the cycle after the edge or the write, and stays there until software clears it.

// File: rtl/extpin_pkg.sv
// Package: shared widths, register addresses, edge codes and the control
// register layout of the external pin capture unit.
package extpin_pkg;

    localparam int COUNT_W = 24;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CAP  = 2'd2;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_t;

    // Layout, LSB first: pin_en[0], edge_sel[2:1], rst_mode[3], irq_en[4], db_en[5]
    typedef struct packed {
        logic      db_en;
        logic      irq_en;
        logic      rst_mode;
        edge_sel_t edge_sel;
        logic      pin_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/extpin_sync.sv
// Module: extpin_sync
// Brings an asynchronous single-bit input into the clk domain through a
// chain of STAGES flops. Assumes the input level is held for at least
// one clock to be seen; no edge is produced here.
module extpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/extpin_debounce.sv
// Module: extpin_debounce
// Level filter: the output takes a new level only when the input and the
// last SAMPLES-1 samples all agree. Assumes a synchronized input.
module extpin_debounce #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic lvl_out
);
    localparam int HIST_W = SAMPLES - 1;

    logic [HIST_W-1:0] hist_q;
    logic              lvl_q;
    logic              agree;

    assign agree = (hist_q == {HIST_W{lvl_in}});

    // Keep the recent sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_W-2:0], lvl_in};
    end

    // Accept the input level once every stored sample matches it.
    always_ff @(posedge clk) begin
        if (!rst_n)     lvl_q <= 1'b0;
        else if (agree) lvl_q <= lvl_in;
    end

    assign lvl_out = lvl_q;

    // A level change must follow a run of identical samples.
    assert_stable_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> ($past(lvl_in) == lvl_q && $past(hist_q) == {HIST_W{lvl_q}}))
        else $error("debounce accepted an unsettled level");
endmodule

// File: rtl/extpin_edge.sv
// Module: extpin_edge
// Remembers the previous filtered level and flags the edge kind picked by
// sel. The spare code gives no edge. Output is combinational for one cycle.
module extpin_edge
    import extpin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  edge_sel_t sel,
    output logic      hit
);
    logic prev_q;

    // Track last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Pick the transition kind the edge code asks for.
    always_comb begin
        case (sel)
            EDGE_FALL: hit = prev_q & ~lvl;
            EDGE_RISE: hit = ~prev_q & lvl;
            EDGE_BOTH: hit = prev_q ^ lvl;
            default:   hit = 1'b0;
        endcase
    end

    // A hit always comes with a level change.
    assert_hit_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (prev_q != $past(prev_q)))
        else $error("edge hit without a level change");
endmodule

// File: rtl/extpin_capture.sv
// Module: extpin_capture (top)
// Watches an external pin, finds the chosen edge and either snapshots the
// live count with an event flag or pulses the counter reset. Assumes
// count_in is synchronous to clk; the counter is outside this block.
module extpin_capture
    import extpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DB_SAMPLES  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_in,
    input  logic [COUNT_W-1:0] count_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CTRL_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [COUNT_W-1:0] rd_data,
    output logic [COUNT_W-1:0] cap_value,
    output logic               cnt_rst,
    output logic               ext_flag,
    output logic               ext_irq
);
    ctrl_t              ctl_q;
    logic [COUNT_W-1:0] cap_q;
    logic               flag_q;
    logic               rst_pulse_q;
    logic               sync_lvl, db_lvl, sel_lvl, hit;
    logic               evt, cap_evt, rst_evt, clr_wr;

    extpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_lvl));

    extpin_debounce #(.SAMPLES(DB_SAMPLES)) u_db (
        .clk(clk), .rst_n(rst_n), .lvl_in(sync_lvl), .lvl_out(db_lvl));

    assign sel_lvl = ctl_q.db_en ? db_lvl : sync_lvl;

    extpin_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sel_lvl), .sel(ctl_q.edge_sel), .hit(hit));

    assign evt     = hit & ctl_q.pin_en;
    assign cap_evt = evt & ~ctl_q.rst_mode;
    assign rst_evt = evt & ctl_q.rst_mode;
    assign clr_wr  = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ctl_q <= '0;
        else if (wr_en && (wr_addr == ADDR_CTRL))    ctl_q <= ctrl_t'(wr_data);
    end

    // Snapshot the live count on a capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= count_in;
    end

    // Event flag: hardware set has priority over write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (cap_evt) flag_q <= 1'b1;
        else if (clr_wr)  flag_q <= 1'b0;
    end

    // One-cycle counter reset per edge in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse_q <= 1'b0;
        else        rst_pulse_q <= rst_evt;
    end

    // Register read mux.
    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = {{(COUNT_W-CTRL_W){1'b0}}, ctl_q};
            ADDR_FLAG: rd_data = {{(COUNT_W-1){1'b0}}, flag_q};
            ADDR_CAP:  rd_data = cap_q;
            default:   rd_data = '0;
        endcase
    end

    assign cap_value = cap_q;
    assign cnt_rst   = rst_pulse_q;
    assign ext_flag  = flag_q;
    assign ext_irq   = flag_q & ctl_q.irq_en;

    assert_capture_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (flag_q && cap_q == $past(count_in)))
        else $error("capture event did not load count and flag");

    assert_reset_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_q |-> ($past(ctl_q.rst_mode && ctl_q.pin_en) && $stable(cap_q)))
        else $error("reset pulse outside reset mode or capture moved");

    assert_pin_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.pin_en |=> (!rst_pulse_q && $stable(cap_q) && !$rose(flag_q)))
        else $error("disabled pin caused an action");

    assert_code_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.edge_sel == EDGE_NONE) |=> (!rst_pulse_q && $stable(cap_q) && !$rose(flag_q)))
        else $error("spare edge code caused an action");

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_wr))
        else $error("flag cleared without a write of 1");
endmodule

// File: tb/extpin_capture_bench.sv
module extpin_capture_bench;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [23:0] count_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [5:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [23:0] rd_data, cap_value;
    logic        cnt_rst, ext_flag, ext_irq;

    int n_run = 0;
    int n_fail = 0;

    always #(TCLK/2) clk = ~clk;

    extpin_capture u_extpin_capture (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_in(count_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cap_value(cap_value), .cnt_rst(cnt_rst),
        .ext_flag(ext_flag), .ext_irq(ext_irq));

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pin_to(input logic v);
        @(negedge clk);
        pin_in = v;
        cyc(8);
    endtask

    task automatic t_reset_R11;
        rd_addr = 2'd0; #1;
        check(rd_data == 0, "R11 ctrl", rd_data, 0);
        check(cap_value == 0 && !ext_flag && !ext_irq && !cnt_rst, "R11 outputs",
              {cap_value[20:0], ext_flag, ext_irq, cnt_rst}, 0);
    endtask

    task automatic t_capture_R4_R6_R7;
        wr(2'd0, 6'h03);
        count_in = 24'h123456;
        pin_to(1'b1);
        check(cap_value == 24'h123456, "R4 capture", cap_value, 24'h123456);
        check(ext_flag == 1'b1, "R4 flag", ext_flag, 1);
        check(ext_irq == 1'b0, "R7 irq masked", ext_irq, 0);
        wr(2'd0, 6'h13); cyc(1);
        check(ext_irq == 1'b1, "R7 irq enabled", ext_irq, 1);
        wr(2'd1, 6'h00); cyc(1);
        check(ext_flag == 1'b1, "R6 write 0 keeps flag", ext_flag, 1);
        wr(2'd1, 6'h01); cyc(1);
        check(ext_flag == 1'b0 && ext_irq == 1'b0, "R6 write 1 clears", {ext_flag, ext_irq}, 0);
    endtask

    task automatic t_edges_R1;
        wr(2'd0, 6'h03);
        count_in = 24'hAAAAAA;
        pin_to(1'b0);
        check(cap_value == 24'h123456 && !ext_flag, "R1 rise code ignores fall", cap_value, 24'h123456);
        wr(2'd0, 6'h01);
        count_in = 24'h000777;
        pin_to(1'b1);
        check(cap_value == 24'h123456, "R1 fall code ignores rise", cap_value, 24'h123456);
        pin_to(1'b0);
        check(cap_value == 24'h000777 && ext_flag, "R1 fall code captures", cap_value, 24'h000777);
        wr(2'd1, 6'h01);
        wr(2'd0, 6'h05);
        count_in = 24'h0BEEF1;
        pin_to(1'b1);
        check(cap_value == 24'h0BEEF1, "R1 both code rise", cap_value, 24'h0BEEF1);
        count_in = 24'h0BEEF2;
        pin_to(1'b0);
        check(cap_value == 24'h0BEEF2, "R1 both code fall", cap_value, 24'h0BEEF2);
        wr(2'd1, 6'h01);
    endtask

    task automatic t_none_R2;
        wr(2'd0, 6'h07);
        count_in = 24'h555555;
        pin_to(1'b1);
        pin_to(1'b0);
        check(cap_value == 24'h0BEEF2 && !ext_flag, "R2 spare code", cap_value, 24'h0BEEF2);
    endtask

    task automatic t_disabled_R3;
        int pulses = 0;
        wr(2'd0, 6'h04);
        count_in = 24'h666666;
        @(negedge clk) pin_in = 1'b1;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (cnt_rst) pulses++; end
        pin_to(1'b0);
        check(cap_value == 24'h0BEEF2 && !ext_flag && pulses == 0, "R3 pin disabled", cap_value, 24'h0BEEF2);
    endtask

    task automatic t_reset_mode_R5;
        int pulses = 0;
        int width = 0;
        wr(2'd0, 6'h0B);
        count_in = 24'h777777;
        @(negedge clk) pin_in = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cnt_rst) begin width++; if (width == 1) pulses++; end
        end
        check(pulses == 1 && width == 1, "R5 single pulse", 24'(width), 1);
        check(!ext_flag && cap_value == 24'h0BEEF2, "R5 no flag no capture", cap_value, 24'h0BEEF2);
        pin_to(1'b0);
        check(!cnt_rst, "R5 rise only", cnt_rst, 0);
    endtask

    task automatic t_debounce_R8;
        wr(2'd0, 6'h23);
        cyc(4);
        count_in = 24'h080808;
        @(negedge clk) pin_in = 1'b1;
        cyc(2);
        pin_in = 1'b0;
        cyc(10);
        check(cap_value == 24'h0BEEF2 && !ext_flag, "R8 glitch rejected", cap_value, 24'h0BEEF2);
        pin_to(1'b1);
        check(cap_value == 24'h080808 && ext_flag, "R8 held level accepted", cap_value, 24'h080808);
        pin_to(1'b0);
        wr(2'd1, 6'h01);
        wr(2'd0, 6'h03);
        count_in = 24'h090909;
        @(negedge clk) pin_in = 1'b1;
        cyc(2);
        pin_in = 1'b0;
        cyc(10);
        check(cap_value == 24'h090909 && ext_flag, "R8 glitch passes unfiltered", cap_value, 24'h090909);
        wr(2'd1, 6'h01);
    endtask

    task automatic t_readonly_R9;
        wr(2'd2, 6'h3F);
        cyc(1);
        rd_addr = 2'd2; #1;
        check(rd_data == 24'h090909 && cap_value == 24'h090909, "R9 capture read-only", rd_data, 24'h090909);
    endtask

    task automatic t_set_wins_R10;
        count_in = 24'h0A0A0A;
        @(negedge clk) pin_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 6'h01;
        @(negedge clk);
        wr_en = 1'b0;
        check(ext_flag == 1'b1 && cap_value == 24'h0A0A0A, "R10 set beats clear", ext_flag, 1);
        wr(2'd1, 6'h01); cyc(1);
        check(ext_flag == 1'b0, "R10 later clear", ext_flag, 0);
    endtask

    initial begin
        cyc(3);
        t_reset_R11();
        @(negedge clk) rst_n = 1'b1;
        cyc(2);
        t_reset_R11();
        t_capture_R4_R6_R7();
        t_edges_R1();
        t_none_R2();
        t_disabled_R3();
        t_reset_mode_R5();
        t_debounce_R8();
        t_readonly_R9();
        t_set_wins_R10();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(TCLK * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule